// File: doc/BRIEF.md
# Mode-Switching Interrupt Frame Pusher

This block saves the state of a task that runs in compatibility mode when an interrupt arrives, and it prepares entry into a privileged handler. A one-cycle start pulse captures a snapshot of the interrupted task. The snapshot holds its six segment selectors, its stack pointer, its flags and its instruction pointer. The pulse also captures the privileged stack pointer and the code selector and offset of the gate target. The block then writes a fixed frame of nine 32-bit words onto the privileged stack, so entry changes both the privilege level and the stack.

Frame words go out on a valid/ready write stream (`wr_valid`, `wr_ready`, `wr_addr`, `wr_data`). A word counts as written in a cycle where both `wr_valid` and `wr_ready` are high, so at most one word is written per clock. While `wr_ready` is low, `wr_valid` stays high and the address and data stay unchanged. When `wr_ready` is held high, the whole frame takes nine consecutive cycles. After the last word is accepted, the block presents the handler's code selector and offset, the new stack pointer, the flags with the compatibility-mode bit cleared, and null data-segment selectors, and it pulses `done`.

Top module: `ifp_frame_pusher`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `done` are 0, and every register-value output is 0.
- R2: A start pulse while idle captures all inputs. In the next cycle `wr_valid` is 1, with `wr_addr` equal to the privileged stack pointer minus 4 and `wr_data` equal to the GS image.
- R3: Words are written in the order GS, FS, DS, ES, SS, ESP, EFLAGS, CS, EIP. Each address is 4 below the previous one, so EIP lands at the privileged stack pointer minus 36. Selector words carry the selector in bits 15:0, with bits 31:16 driven as zero.
- R4: While `wr_valid` is high and `wr_ready` is low, the pending word is held with the same address and data. Each accepted handshake advances to the next word.
- R5: A start pulse while `busy` is high is ignored. The frame in progress and its captured values do not change.
- R6: `done` is high for exactly one cycle: the cycle after the EIP word is accepted. `busy` falls in that same cycle.
- R7: From the `done` cycle on, `out_cs` and `out_eip` hold the captured gate selector and offset, and `out_esp` holds the privileged stack pointer minus 36.
- R8: From the `done` cycle on, `out_flags` equals the captured flags with bit 17 (compatibility mode) cleared and every other bit unchanged.
- R9: While the frame is being written, the four data-segment outputs show the captured ES, DS, FS and GS values. From the `done` cycle on, they are the null selector 0.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame push (taken only when idle) |
| busy | output | 1 | Frame push in progress |
| in_es | input | 16 | Interrupted task ES selector |
| in_ds | input | 16 | Interrupted task DS selector |
| in_fs | input | 16 | Interrupted task FS selector |
| in_gs | input | 16 | Interrupted task GS selector |
| in_ss | input | 16 | Interrupted task SS selector |
| in_cs | input | 16 | Interrupted task CS selector |
| in_esp | input | 32 | Interrupted task stack pointer |
| in_flags | input | 32 | Interrupted task flags |
| in_eip | input | 32 | Interrupted task instruction pointer |
| priv_esp | input | 32 | Top of the privileged stack |
| gate_cs | input | 16 | Handler code selector from the gate |
| gate_eip | input | 32 | Handler offset from the gate |
| wr_valid | output | 1 | Frame word valid |
| wr_ready | input | 1 | Memory accepts the word this cycle |
| wr_addr | output | 32 | Byte address of the frame word |
| wr_data | output | 32 | Frame word |
| done | output | 1 | One-cycle pulse: new state valid |
| out_cs | output | 16 | New code selector |
| out_eip | output | 32 | New instruction pointer |
| out_esp | output | 32 | New stack pointer |
| out_flags | output | 32 | New flags |
| out_es | output | 16 | ES register value |
| out_ds | output | 16 | DS register value |
| out_fs | output | 16 | FS register value |
| out_gs | output | 16 | GS register value |

## Verification
Assertions check four rules on every cycle:
- a stalled word keeps its address and data;
- the word slot does not move while start is raised during a stall;
- `done` is a single cycle that follows an accepted write;
- at `done`, the segment outputs are null and the compatibility-mode flag is clear.

The full contents of the frame can only be shown by the bench's scenarios. This covers the word order, the address of each word, and zero upper halves on selector words. The scenarios also show that a start raised mid-frame leaves the captured snapshot untouched, that the handler selector, offset and stack pointer come out correctly, and that flags with the compatibility bit already clear pass through unchanged.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int WORD_W      = 32;
  localparam int SEL_W       = 16;
  localparam int FRAME_WORDS = 9;
  localparam int SLOT_W      = $clog2(FRAME_WORDS);
  localparam int STEP_BYTES  = WORD_W / 8;

  // frame order: first written (highest address) to last written (lowest)
  typedef enum logic [SLOT_W-1:0] {
    SLOT_GS, SLOT_FS, SLOT_DS, SLOT_ES, SLOT_SS,
    SLOT_ESP, SLOT_FLAGS, SLOT_CS, SLOT_EIP
  } slot_e;

  typedef struct packed {
    logic [SEL_W-1:0]  gs;
    logic [SEL_W-1:0]  fs;
    logic [SEL_W-1:0]  ds;
    logic [SEL_W-1:0]  es;
    logic [SEL_W-1:0]  ss;
    logic [SEL_W-1:0]  cs;
    logic [WORD_W-1:0] esp;
    logic [WORD_W-1:0] flags;
    logic [WORD_W-1:0] eip;
  } task_img_t;
endpackage

// File: rtl/ifp_slot_mux.sv
module ifp_slot_mux
  import ifp_pkg::*;
(
  input  task_img_t         img,
  input  slot_e             slot,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - SEL_W;

  always_comb begin
    case (slot)
      SLOT_GS:    word = {{PAD_W{1'b0}}, img.gs};
      SLOT_FS:    word = {{PAD_W{1'b0}}, img.fs};
      SLOT_DS:    word = {{PAD_W{1'b0}}, img.ds};
      SLOT_ES:    word = {{PAD_W{1'b0}}, img.es};
      SLOT_SS:    word = {{PAD_W{1'b0}}, img.ss};
      SLOT_ESP:   word = img.esp;
      SLOT_FLAGS: word = img.flags;
      SLOT_CS:    word = {{PAD_W{1'b0}}, img.cs};
      SLOT_EIP:   word = img.eip;
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/ifp_addr_gen.sv
module ifp_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  // pre-decrement: the first word sits one step below the base
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base - STEP_V;
    else if (step) addr <= addr - STEP_V;
  end
endmodule

// File: rtl/ifp_seq.sv
module ifp_seq
  import ifp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  wr_ready,
  output logic  busy,
  output slot_e slot,
  output logic  launch,
  output logic  advance,
  output logic  finish
);
  logic accept;

  assign launch  = start && !busy;
  assign accept  = busy && wr_ready;
  assign finish  = accept && (slot == SLOT_EIP);
  assign advance = accept && !finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= SLOT_GS;
    end else if (launch) begin
      busy <= 1'b1;
      slot <= SLOT_GS;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (advance) begin
      slot <= slot_e'(slot + SLOT_W'(1));
    end
  end

  // R5: a start during a stalled frame must not move the slot
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !wr_ready |=> busy && $stable(slot));

  // R3: every accepted non-final word advances exactly one slot
  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> busy && (slot != SLOT_GS));
endmodule

// File: rtl/ifp_frame_pusher.sv
module ifp_frame_pusher
  import ifp_pkg::*;
#(
  parameter int VM_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  input  logic [SEL_W-1:0]  in_es,
  input  logic [SEL_W-1:0]  in_ds,
  input  logic [SEL_W-1:0]  in_fs,
  input  logic [SEL_W-1:0]  in_gs,
  input  logic [SEL_W-1:0]  in_ss,
  input  logic [SEL_W-1:0]  in_cs,
  input  logic [WORD_W-1:0] in_esp,
  input  logic [WORD_W-1:0] in_flags,
  input  logic [WORD_W-1:0] in_eip,
  input  logic [WORD_W-1:0] priv_esp,
  input  logic [SEL_W-1:0]  gate_cs,
  input  logic [WORD_W-1:0] gate_eip,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic [SEL_W-1:0]  out_cs,
  output logic [WORD_W-1:0] out_eip,
  output logic [WORD_W-1:0] out_esp,
  output logic [WORD_W-1:0] out_flags,
  output logic [SEL_W-1:0]  out_es,
  output logic [SEL_W-1:0]  out_ds,
  output logic [SEL_W-1:0]  out_fs,
  output logic [SEL_W-1:0]  out_gs
);
  localparam int NUM_DSEG = 4;
  localparam logic [WORD_W-1:0] VM_MASK = WORD_W'(1) << VM_BIT;

  task_img_t         img_q;
  logic [SEL_W-1:0]  gate_cs_q;
  logic [WORD_W-1:0] gate_eip_q;
  slot_e             slot;
  logic              launch, advance, finish;

  ifp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_ready (wr_ready),
    .busy     (busy),
    .slot     (slot),
    .launch   (launch),
    .advance  (advance),
    .finish   (finish)
  );

  ifp_addr_gen #(.ADDR_W(WORD_W), .STEP(STEP_BYTES)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .step  (advance),
    .base  (priv_esp),
    .addr  (wr_addr)
  );

  ifp_slot_mux u_mux (
    .img  (img_q),
    .slot (slot),
    .word (wr_data)
  );

  assign wr_valid = busy;

  // snapshot of the interrupted task and the gate target
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q      <= '0;
      gate_cs_q  <= '0;
      gate_eip_q <= '0;
    end else if (launch) begin
      img_q.gs    <= in_gs;
      img_q.fs    <= in_fs;
      img_q.ds    <= in_ds;
      img_q.es    <= in_es;
      img_q.ss    <= in_ss;
      img_q.cs    <= in_cs;
      img_q.esp   <= in_esp;
      img_q.flags <= in_flags;
      img_q.eip   <= in_eip;
      gate_cs_q   <= gate_cs;
      gate_eip_q  <= gate_eip;
    end
  end

  // control-transfer state presented once the frame is complete
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      out_cs    <= '0;
      out_eip   <= '0;
      out_esp   <= '0;
      out_flags <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        out_cs    <= gate_cs_q;
        out_eip   <= gate_eip_q;
        out_esp   <= wr_addr;
        out_flags <= img_q.flags & ~VM_MASK;
      end
    end
  end

  // data-segment registers: take task values at launch, null at finish
  logic [SEL_W-1:0] dseg_in [NUM_DSEG];
  logic [SEL_W-1:0] dseg_q  [NUM_DSEG];
  assign dseg_in[0] = in_es;
  assign dseg_in[1] = in_ds;
  assign dseg_in[2] = in_fs;
  assign dseg_in[3] = in_gs;

  for (genvar g = 0; g < NUM_DSEG; g++) begin : g_dseg
    always_ff @(posedge clk) begin
      if (!rst_n)      dseg_q[g] <= '0;
      else if (launch) dseg_q[g] <= dseg_in[g];
      else if (finish) dseg_q[g] <= '0;
    end
  end

  assign out_es = dseg_q[0];
  assign out_ds = dseg_q[1];
  assign out_fs = dseg_q[2];
  assign out_gs = dseg_q[3];

  // R4: a stalled word keeps its address and data
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6: done is one cycle wide and follows an accepted write
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready) && !busy);

  // R9: null data selectors when the handler is entered
  a_r9_null_dseg: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_es == '0) && (out_ds == '0) && (out_fs == '0) && (out_gs == '0));

  // R8: compatibility-mode flag is clear at handler entry
  a_r8_vm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_flags[VM_BIT]);
endmodule

// File: tb/tb_ifp_frame_pusher.sv
module tb_ifp_frame_pusher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic [15:0] in_es = '0, in_ds = '0, in_fs = '0, in_gs = '0, in_ss = '0, in_cs = '0;
  logic [31:0] in_esp = '0, in_flags = '0, in_eip = '0, priv_esp = '0, gate_eip = '0;
  logic [15:0] gate_cs = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        done;
  logic [15:0] out_cs, out_es, out_ds, out_fs, out_gs;
  logic [31:0] out_eip, out_esp, out_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ifp_frame_pusher dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .in_es(in_es), .in_ds(in_ds), .in_fs(in_fs), .in_gs(in_gs),
    .in_ss(in_ss), .in_cs(in_cs), .in_esp(in_esp), .in_flags(in_flags),
    .in_eip(in_eip), .priv_esp(priv_esp), .gate_cs(gate_cs), .gate_eip(gate_eip),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .out_cs(out_cs), .out_eip(out_eip), .out_esp(out_esp),
    .out_flags(out_flags), .out_es(out_es), .out_ds(out_ds), .out_fs(out_fs),
    .out_gs(out_gs)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected frame contents, snapshot held here independently of the design
  logic [15:0] e_es, e_ds, e_fs, e_gs, e_ss, e_cs, e_gcs;
  logic [31:0] e_esp, e_flags, e_eip, e_priv, e_geip;

  function automatic logic [31:0] exp_word(input int k);
    case (k)
      0: return {16'h0, e_gs};
      1: return {16'h0, e_fs};
      2: return {16'h0, e_ds};
      3: return {16'h0, e_es};
      4: return {16'h0, e_ss};
      5: return e_esp;
      6: return e_flags;
      7: return {16'h0, e_cs};
      default: return e_eip;
    endcase
  endfunction

  task automatic load_inputs(input logic [31:0] seed, input logic [31:0] flags, input logic [31:0] pesp);
    in_es = seed[15:0] ^ 16'h1111; in_ds = seed[15:0] ^ 16'h2222;
    in_fs = seed[15:0] ^ 16'h3333; in_gs = seed[15:0] ^ 16'h4444;
    in_ss = seed[15:0] ^ 16'h5555; in_cs = seed[15:0] ^ 16'h6666;
    in_esp = seed ^ 32'hA5A5_0F0F; in_eip = seed ^ 32'h0123_4567;
    in_flags = flags; priv_esp = pesp;
    gate_cs = seed[31:16] ^ 16'h0808; gate_eip = seed ^ 32'hDEAD_0000;
    e_es = in_es; e_ds = in_ds; e_fs = in_fs; e_gs = in_gs; e_ss = in_ss; e_cs = in_cs;
    e_esp = in_esp; e_eip = in_eip; e_flags = in_flags; e_priv = pesp;
    e_gcs = gate_cs; e_geip = gate_eip;
  endtask

  // run one frame; ready follows pattern bit (cycle mod 32); start re-raised mid-frame when poke
  task automatic push_frame(input logic [31:0] ready_pat, input bit poke, input string tag);
    int n = 0;
    int cyc = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", {31'h0, busy}, 32'h1);
    chk(wr_valid === 1'b1 && wr_addr === e_priv - 32'd4 && wr_data === {16'h0, e_gs},
        "R2 first word", wr_addr, e_priv - 32'd4);
    chk(out_ds === e_ds && out_gs === e_gs && out_es === e_es && out_fs === e_fs,
        "R9 task selectors while busy", {16'h0, out_ds}, {16'h0, e_ds});
    if (poke) begin
      // change every input; none of it may reach the frame (R5)
      in_gs = ~in_gs; in_eip = ~in_eip; priv_esp = ~priv_esp; in_flags = ~in_flags;
      gate_cs = ~gate_cs; in_ds = ~in_ds;
    end
    while (n < 9 && cyc < 300) begin
      wr_ready = ready_pat[cyc % 32];
      if (poke) start = (cyc < 6);
      chk(done === 1'b0 && wr_valid === 1'b1, "R6 no done mid-frame", {31'h0, done}, 32'h0);
      if (wr_ready) begin
        chk(wr_addr === e_priv - 32'(4 * (n + 1)), {tag, " R3 address"}, wr_addr, e_priv - 32'(4 * (n + 1)));
        chk(wr_data === exp_word(n), {tag, " R3 R4 data"}, wr_data, exp_word(n));
        n++;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    wr_ready = 1'b0;
    chk(done === 1'b1, {tag, " R6 done after last write"}, {31'h0, done}, 32'h1);
    chk(busy === 1'b0, {tag, " R10 busy low at done"}, {31'h0, busy}, 32'h0);
    chk(out_cs === e_gcs && out_eip === e_geip, {tag, " R7 gate target"}, out_eip, e_geip);
    chk(out_esp === e_priv - 32'd36, {tag, " R7 new stack pointer"}, out_esp, e_priv - 32'd36);
    chk(out_flags === (e_flags & ~32'h0002_0000), {tag, " R8 flags"}, out_flags, e_flags & ~32'h0002_0000);
    chk(out_es === 16'h0 && out_ds === 16'h0 && out_fs === 16'h0 && out_gs === 16'h0,
        {tag, " R9 null selectors"}, {out_es, out_ds}, 32'h0);
    @(negedge clk);
    chk(done === 1'b0 && wr_valid === 1'b0, {tag, " R6 done one cycle"}, {31'h0, done}, 32'h0);
    chk(out_eip === e_geip, {tag, " R7 outputs hold"}, out_eip, e_geip);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && wr_valid === 1'b0 && done === 1'b0, "R1 control idle", {29'h0, busy, wr_valid, done}, 32'h0);
    chk(out_cs === 16'h0 && out_eip === 32'h0 && out_esp === 32'h0 && out_flags === 32'h0 &&
        out_es === 16'h0 && out_ds === 16'h0 && out_fs === 16'h0 && out_gs === 16'h0,
        "R1 outputs zero", out_eip, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_full_rate();
    load_inputs(32'h1357_9BDF, 32'h0002_0202, 32'h0000_8000);
    push_frame(32'hFFFF_FFFF, 1'b0, "full-rate");
  endtask

  task automatic t_backpressure();
    load_inputs(32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h0010_0004);
    push_frame(32'b1001_0110_0011_1010_0101_1100_0001_0010, 1'b0, "stalls");
  endtask

  task automatic t_start_while_busy();
    load_inputs(32'h0BAD_BEEF, 32'h0003_0046, 32'h0000_0100);
    push_frame(32'b0101_1011_0110_1101_1010_0110_1100_0110, 1'b1, "R5 start ignored");
  endtask

  task automatic t_vm_already_clear();
    load_inputs(32'h7777_1234, 32'h0000_0893, 32'h0004_0000);
    push_frame(32'hFFFF_FFFF, 1'b0, "vm-clear");
  endtask

  initial begin
    t_reset();
    t_full_rate();
    t_backpressure();
    t_start_while_busy();
    t_vm_already_clear();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule